// File: doc/BRIEF.md
# Deserializer Bitslip Word Shifter

This block sits right after a serial-to-parallel converter. It moves the boundary of the parallel word one serial bit at a time. Each word arrives as a raw J-bit vector on the parallel clock, with the earliest serial bit in the MSB. The block holds the word from the previous clock. It forms a 2J-bit stream from that word and the current one, and outputs a J-bit window of it. A slip counter sets where the window starts.

Alignment logic upstream looks for a known control character. While the character has not been found, it raises the slip request, one rising edge per bit to move. The slip counter runs to a programmable rollover value and then wraps to zero, and a one-cycle flag marks each wrap. A synchronous bitslip reset puts the counter back to the default position. This reset does not depend on any clocking or phase-selection state.

Top module: `bitslip_shifter`

## Requirements
- R1: Each rising edge seen on `slipReq` advances `slipCount` by exactly one. No other input changes `slipCount`, apart from `slipRst`.
- R2: The parameter `ROLL_CNT` must be at least `WORD_W`, and a smaller value is rejected at elaboration. `slipCount` always stays in the range 0 to `ROLL_CNT`-1.
- R3: If `slipReq` is held high for several clocks, that counts as one slip. A new slip needs `slipReq` to go low first.
- R4: `slipRst` is sampled on the clock edge. After any clock edge where it is high, `slipCount` is 0, `rollover` is 0, `dataOut` is 0 and the stored previous word is 0. A request edge that is still in flight is dropped.
- R5: When `slipCount` is `ROLL_CNT`-1, the next slip sets it to 0. `rollover` is high only during the clock cycle right after that wrap edge.
- R6: `dataOut` is bits [2J-1-s : J-s] of the concatenation {previous word, current word}, with s = `slipCount` mod `WORD_W`. It is updated on every edge, so with s = 0 it shows the word that was captured one clock earlier.
- R7: Say `slipReq` is first sampled high at edge k. Then `slipCount` changes at edge k+1, and `dataOut` first uses the new offset at edge k+2.
- R8: `rollover` stays low on every edge that does not wrap the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| slipRst | input | 1 | Synchronous bitslip reset, active high |
| slipReq | input | 1 | Slip request, edge detected |
| rawWord | input | WORD_W | Unaligned word from the deserializer, earliest bit in MSB |
| dataOut | output | WORD_W | Realigned word |
| slipCount | output | $clog2(ROLL_CNT) | Current slip position |
| rollover | output | 1 | One-cycle flag when the slip counter wraps to 0 |

## Verification
The bench builds the block with `WORD_W` = 8 and `ROLL_CNT` = 11. Because the rollover value is larger than the word width and not a multiple of it, slip counts 8, 9 and 10 map back to window offsets 0, 1 and 2. This also makes the wrap from 10 to 0 differ from the natural wrap of the offset, so a design that uses the slip count as the offset directly, or wraps at the word width, gives outputs that differ from the model. The random raw words make every window offset visible in `dataOut`.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;

  // Strobes sent from the slip control to the datapath
  typedef struct packed {
    logic clear;    // synchronous bitslip reset
    logic advance;  // one slip this cycle
    logic wrap;     // this slip wraps the counter to zero
  } slipStrobes_t;

endpackage

// File: rtl/bitslip_ctrl.sv
module bitslip_ctrl
  import bitslip_pkg::*;
#(
  parameter int ROLL_CNT = 8,
  localparam int CNT_W = $clog2(ROLL_CNT)
) (
  input  logic             clk,
  input  logic             slipRst,
  input  logic             slipReq,
  output slipStrobes_t     strobes,
  output logic [CNT_W-1:0] slipCount,
  output logic             rollover
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROLL_CNT - 1);

  logic reqQ;
  logic reqQd;
  logic rise;
  logic atLast;

  // Edge detection on the registered request level
  assign rise   = reqQ & ~reqQd;
  assign atLast = (slipCount == LAST);

  always_comb begin
    strobes.clear   = slipRst;
    strobes.advance = rise & ~slipRst;
    strobes.wrap    = rise & ~slipRst & atLast;
  end

  always_ff @(posedge clk) begin
    if (slipRst) begin
      reqQ      <= 1'b0;
      reqQd     <= 1'b0;
      slipCount <= '0;
      rollover  <= 1'b0;
    end else begin
      reqQ     <= slipReq;
      reqQd    <= reqQ;
      rollover <= strobes.wrap;
      if (strobes.advance) begin
        slipCount <= atLast ? '0 : slipCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bitslip_datapath.sv
module bitslip_datapath
  import bitslip_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int OFF_W = $clog2(WORD_W),
  localparam int CAT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  slipStrobes_t      strobes,
  input  logic [WORD_W-1:0] rawWord,
  output logic [WORD_W-1:0] dataOut
);

  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(WORD_W - 1);

  logic [WORD_W-1:0] prevWord;
  logic [OFF_W-1:0]  offset;
  logic [CAT_W-1:0]  catWord;
  logic [WORD_W-1:0] cand [WORD_W];

  assign catWord = {prevWord, rawWord};

  // One candidate window per possible bit offset
  for (genvar i = 0; i < WORD_W; i++) begin : g_win
    assign cand[i] = catWord[CAT_W-1-i -: WORD_W];
  end

  // Offset tracks slip count modulo the word width
  always_ff @(posedge clk) begin
    if (strobes.clear || strobes.wrap) begin
      offset <= '0;
    end else if (strobes.advance) begin
      offset <= (offset == OFF_LAST) ? '0 : offset + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      prevWord <= '0;
      dataOut  <= '0;
    end else begin
      prevWord <= rawWord;
      dataOut  <= cand[offset];
    end
  end

endmodule

// File: rtl/bitslip_shifter.sv
module bitslip_shifter
  import bitslip_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int ROLL_CNT = 8,
  localparam int CNT_W   = $clog2(ROLL_CNT)
) (
  input  logic              clk,
  input  logic              slipRst,
  input  logic              slipReq,
  input  logic [WORD_W-1:0] rawWord,
  output logic [WORD_W-1:0] dataOut,
  output logic [CNT_W-1:0]  slipCount,
  output logic              rollover
);

  // R2: the counter must be able to step through a whole word
  if (ROLL_CNT < WORD_W) begin : g_badRoll
    $error("ROLL_CNT must be at least WORD_W");
  end

  slipStrobes_t strobes;

  bitslip_ctrl #(.ROLL_CNT(ROLL_CNT)) u_ctrl (
    .clk      (clk),
    .slipRst  (slipRst),
    .slipReq  (slipReq),
    .strobes  (strobes),
    .slipCount(slipCount),
    .rollover (rollover)
  );

  bitslip_datapath #(.WORD_W(WORD_W)) u_data (
    .clk    (clk),
    .strobes(strobes),
    .rawWord(rawWord),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/bitslip_shifter_chk.sv
module bitslip_shifter_chk #(
  parameter int WORD_W   = 8,
  parameter int ROLL_CNT = 8,
  localparam int CNT_W   = $clog2(ROLL_CNT)
) (
  input logic             clk,
  input logic             slipRst,
  input logic [CNT_W-1:0] slipCount,
  input logic             rollover
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROLL_CNT - 1);

  assert_clear_R4: assert property (@(posedge clk)
    slipRst |=> (slipCount == '0 && !rollover));

  assert_range_R2: assert property (@(posedge clk) disable iff (slipRst)
    slipCount <= LAST);

  assert_step_R1: assert property (@(posedge clk) disable iff (slipRst)
    (!$past(slipRst) && slipCount != $past(slipCount)) |->
      (slipCount == (($past(slipCount) == LAST) ? '0 : $past(slipCount) + 1'b1)));

  assert_single_R3: assert property (@(posedge clk) disable iff (slipRst)
    (!$past(slipRst) && slipCount != $past(slipCount)) |=> $stable(slipCount));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (slipRst)
    rollover |=> !rollover);

  assert_wrap_R8: assert property (@(posedge clk) disable iff (slipRst)
    rollover |-> (slipCount == '0 && $past(slipCount) == LAST));

endmodule

bind bitslip_shifter bitslip_shifter_chk #(.WORD_W(WORD_W), .ROLL_CNT(ROLL_CNT)) u_chk (
  .clk      (clk),
  .slipRst  (slipRst),
  .slipCount(slipCount),
  .rollover (rollover)
);

// File: tb/bitslip_shifter_tb.sv
module bitslip_shifter_tb;

  localparam int W     = 8;
  localparam int ROLL  = 11;
  localparam int CNT_W = $clog2(ROLL);

  logic             clk = 1'b0;
  logic             slipRst = 1'b1;
  logic             slipReq = 1'b0;
  logic [W-1:0]     rawWord = '0;
  logic [W-1:0]     dataOut;
  logic [CNT_W-1:0] slipCount;
  logic             rollover;

  int checks = 0;
  int fails  = 0;
  int wraps  = 0;

  always #10 clk = ~clk;

  bitslip_shifter #(.WORD_W(W), .ROLL_CNT(ROLL)) u_dut (
    .clk(clk), .slipRst(slipRst), .slipReq(slipReq), .rawWord(rawWord),
    .dataOut(dataOut), .slipCount(slipCount), .rollover(rollover)
  );

  // Behavioural reference: request history queue, integer state
  int reqHist[$];
  int mCount = 0;
  int mOff   = 0;
  int mRoll  = 0;
  int mPrev  = 0;
  int mOut   = 0;

  always @(posedge clk) begin
    int cat;
    int rise;
    if (slipRst) begin
      reqHist = {0, 0};
      mCount = 0; mOff = 0; mRoll = 0; mPrev = 0; mOut = 0;
    end else begin
      cat  = (mPrev << W) | int'(rawWord);
      mOut = (cat >> (W - mOff)) & ((1 << W) - 1);
      rise = (reqHist[1] == 1 && reqHist[0] == 0) ? 1 : 0;
      mRoll = 0;
      if (rise == 1) begin
        mCount = mCount + 1;
        if (mCount == ROLL) begin
          mCount = 0;
          mRoll  = 1;
        end
        mOff = mCount % W;
      end
      void'(reqHist.pop_front());
      reqHist.push_back(int'(slipReq));
      mPrev = int'(rawWord);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance one clock; compare at falling edge, then drive new inputs
  task automatic step(input logic req);
    @(negedge clk);
    check("R6 dataOut", int'(dataOut), mOut);
    check("R1 slipCount", int'(slipCount), mCount);
    check("R5 rollover", int'(rollover), mRoll);
    if (rollover) wraps++;
    slipReq = req;
    rawWord = W'($urandom);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c0;
    // reset state (R4)
    repeat (3) @(negedge clk);
    check("R4 reset count", int'(slipCount), 0);
    check("R4 reset rollover", int'(rollover), 0);
    check("R4 reset data", int'(dataOut), 0);
    slipRst = 1'b0;
    repeat (4) step(1'b0);

    // single pulses, latency (R7)
    for (int p = 0; p < 3; p++) begin
      c0 = int'(slipCount);
      step(1'b1);
      step(1'b0);
      check("R7 count unchanged after sampling edge", int'(slipCount), c0);
      step(1'b0);
      check("R7 count changed one edge later", int'(slipCount), c0 + 1);
      repeat (3) step(1'b0);
    end

    // held level counts once (R3)
    c0 = int'(slipCount);
    repeat (6) step(1'b1);
    repeat (4) step(1'b0);
    check("R3 held level is one slip", int'(slipCount), c0 + 1);

    // alternating request: each rise counts, run through wraps (R5, R6)
    for (int p = 0; p < 30; p++) begin
      step(1'b1);
      step(1'b0);
    end
    repeat (4) step(1'b0);
    check("R5 wraps observed", (wraps >= 2) ? 1 : 0, 1);
    check("R2 count in range", (int'(slipCount) < ROLL) ? 1 : 0, 1);

    // reset with pending edge in flight (R4)
    step(1'b1);
    @(negedge clk);
    slipRst = 1'b1;
    slipReq = 1'b0;
    @(negedge clk);
    check("R4 mid-run clear count", int'(slipCount), 0);
    check("R4 mid-run clear data", int'(dataOut), 0);
    slipRst = 1'b0;
    repeat (5) step(1'b0);
    check("R4 pending edge dropped", int'(slipCount), 0);

    // walk every count value up to last and wrap once more (R2, R8)
    for (int p = 0; p < ROLL - 1; p++) begin
      step(1'b1);
      step(1'b0);
      step(1'b0);
    end
    repeat (2) step(1'b0);
    check("R2 reaches last value", int'(slipCount), ROLL - 1);
    check("R8 no flag before wrap", int'(rollover), 0);
    step(1'b1);
    step(1'b0);
    step(1'b0);
    check("R5 wrapped to zero", int'(slipCount), 0);
    repeat (6) step(1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule